// File: doc/BRIEF.md
# Sixteen-Entry FIFO with Slot-Driven Output and Optional Hold Latch

This block is a single-clock first-in first-out buffer of sixteen words. It has no output register after the storage array. The data output is wired to the array entry that the most recent accepted read came from. The word just read therefore stays visible until the next read, and nothing clears it. Because the output is the array entry itself, a later write that reuses that entry changes what the output shows.

After the buffer has emptied, the sixteenth write lands in the entry that was read last. Two features guard against this. A hold-latch mode, selected by an input, copies each word into a private register as it is read and drives the output from that register. An early-full flag rises when exactly fifteen words are stored, so a writer can stop one entry short and leave the last-read entry intact. A write while full and a read while empty are refused, and each raises an error pulse that lasts one cycle.

Top module: `showslot_fifo`

## Requirements
- R1: The buffer holds 16 words. After 16 accepted writes with no reads, `fullFlag` is 1, `emptyFlag` is 0, and the two flags are never both 1.
- R2: Words come out in the order they were accepted. One cycle after an accepted read, `rdData` shows the word that was read.
- R3: When `holdEn` is 0, `rdData` keeps the last word read through idle cycles and through writes to other entries, until the next accepted read.
- R4: When `holdEn` is 0 and an accepted write targets the entry of the last read, `rdData` shows the newly written word one cycle later. Starting from empty, this happens on the 16th write.
- R5: When `holdEn` is 1, `rdData` keeps the last word read through any number of writes, including the write that fills the buffer.
- R6: A write while `fullFlag` is 1 is ignored and does not change the stored contents. `wrErr` is 1 in the following cycle only.
- R7: A read while `emptyFlag` is 1 is ignored and leaves `rdData` unchanged. `rdErr` is 1 in the following cycle only.
- R8: `almostFull` is 1 exactly when 15 words are stored.
- R9: A read and a write in the same cycle, both legal, are both accepted and leave the occupancy unchanged.
- R10: After reset the buffer is empty: `emptyFlag`=1, `fullFlag`=0, `almostFull`=0, `wrErr`=0 and `rdErr`=0.
- R11: Until the first accepted read after reset, `rdData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| holdEn | input | 1 | 1 drives the output from the hold latch |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Word to store |
| fullFlag | output | 1 | Sixteen words stored |
| almostFull | output | 1 | Fifteen words stored |
| wrErr | output | 1 | One-cycle pulse after a refused write |
| rdEn | input | 1 | Read strobe |
| emptyFlag | output | 1 | No words stored |
| rdData | output | DATA_W | Last word read |
| rdErr | output | 1 | One-cycle pulse after a refused read |

## Verification
Two events can fall in the same cycle: an accepted read and an accepted write. The bench first leaves two words in the buffer. It then raises both strobes together for several cycles, with the write side fed fresh words. The scoreboard checks each word as it emerges. After the joint phase, exactly the two remaining words must drain before `emptyFlag` returns, which shows that the occupancy did not drift. A second overlap, between the write that fills the buffer and the entry of the last read, is provoked in both `holdEn` modes, and the output is judged on the cycle after that write.

// File: rtl/showslot_pkg.sv
package showslot_pkg;
  typedef struct packed {
    logic wrAcc;
    logic rdAcc;
  } fifoStrobes_t;
endpackage

// File: rtl/showslot_ctrl.sv
module showslot_ctrl
  import showslot_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  output fifoStrobes_t      strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              fullFlag,
  output logic              emptyFlag,
  output logic              almostFull,
  output logic              wrErr,
  output logic              rdErr
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] WRAP_ONLY = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [PTR_W-1:0] ONE_SHORT = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wrPtr, rdPtr, occupancy;

  assign occupancy  = wrPtr - rdPtr;
  assign emptyFlag  = (wrPtr == rdPtr);
  assign fullFlag   = ((wrPtr ^ rdPtr) == WRAP_ONLY);
  assign almostFull = (occupancy == ONE_SHORT);

  assign strobes.wrAcc = wrEn && !fullFlag;
  assign strobes.rdAcc = rdEn && !emptyFlag;
  assign wrAddr = wrPtr[ADDR_W-1:0];
  assign rdAddr = rdPtr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      wrErr <= 1'b0;
      rdErr <= 1'b0;
    end else begin
      if (strobes.wrAcc) wrPtr <= wrPtr + 1'b1;
      if (strobes.rdAcc) rdPtr <= rdPtr + 1'b1;
      wrErr <= wrEn && fullFlag;
      rdErr <= rdEn && emptyFlag;
    end
  end

  p_flags_exclusive_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(fullFlag && emptyFlag));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && fullFlag) |=> (wrErr && $stable(wrPtr)));
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && emptyFlag) |=> (rdErr && $stable(rdPtr)));
  p_err_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn) |=> !wrErr);
  p_early_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    (almostFull && strobes.wrAcc && !strobes.rdAcc) |=> fullFlag);
  p_joint_count_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn && !fullFlag && !emptyFlag) |=> $stable(occupancy));
endmodule

// File: rtl/showslot_data.sv
module showslot_data
  import showslot_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 4,
  parameter bit HOLD_LATCH = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              holdEn,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] slots [DEPTH];
  logic [ADDR_W-1:0] lastAddr;
  logic              readSeen;
  logic [DATA_W-1:0] slotView;

  always_ff @(posedge clk) begin
    if (strobes.wrAcc) slots[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastAddr <= '0;
      readSeen <= 1'b0;
    end else if (strobes.rdAcc) begin
      lastAddr <= rdAddr;
      readSeen <= 1'b1;
    end
  end

  assign slotView = readSeen ? slots[lastAddr] : '0;

  generate
    if (HOLD_LATCH) begin : g_hold
      logic [DATA_W-1:0] holdReg;
      always_ff @(posedge clk) begin
        if (!rstN)                holdReg <= '0;
        else if (strobes.rdAcc)   holdReg <= slots[rdAddr];
      end
      assign rdData = holdEn ? holdReg : slotView;

      p_hold_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
        (holdEn && !strobes.rdAcc) |=> (!holdEn || $stable(rdData)));
    end else begin : g_direct
      logic unusedHold;
      assign unusedHold = holdEn;
      assign rdData = slotView;
    end
  endgenerate

  p_shows_overwrite_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!holdEn && readSeen && strobes.wrAcc && !strobes.rdAcc && wrAddr == lastAddr)
      |=> (holdEn || rdData == $past(wrData)));
  p_keeps_word_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!holdEn && !strobes.rdAcc && !(strobes.wrAcc && wrAddr == lastAddr))
      |=> (holdEn || $stable(rdData)));
  p_zero_first_r11: assert property (@(posedge clk) disable iff (!rstN)
    !readSeen |-> (rdData == '0));
endmodule

// File: rtl/showslot_fifo.sv
module showslot_fifo
  import showslot_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 4,
  parameter bit HOLD_LATCH = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              holdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              fullFlag,
  output logic              almostFull,
  output logic              wrErr,
  input  logic              rdEn,
  output logic              emptyFlag,
  output logic [DATA_W-1:0] rdData,
  output logic              rdErr
);
  fifoStrobes_t      strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  showslot_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullFlag(fullFlag), .emptyFlag(emptyFlag), .almostFull(almostFull),
    .wrErr(wrErr), .rdErr(rdErr)
  );

  showslot_data #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .HOLD_LATCH(HOLD_LATCH)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .holdEn(holdEn), .rdData(rdData)
  );
endmodule

// File: tb/showslot_fifo_test.sv
`timescale 1ns/1ps
module showslot_fifo_test;
  localparam int DW = 16;

  logic clk = 1'b0, rstN = 1'b0, holdEn = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic fullFlag, almostFull, wrErr, emptyFlag, rdErr;
  logic [DW-1:0] rdData;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [DW-1:0] mdl[$];
  logic [DW-1:0] expQ[$];
  logic [DW-1:0] lastWord;
  bit rdIssued = 1'b0;

  always #2 clk = ~clk;

  showslot_fifo #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .holdEn(holdEn), .wrEn(wrEn), .wrData(wrData),
    .fullFlag(fullFlag), .almostFull(almostFull), .wrErr(wrErr),
    .rdEn(rdEn), .emptyFlag(emptyFlag), .rdData(rdData), .rdErr(rdErr)
  );

  task automatic checkEq(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: a read accepted at a rising edge is judged at the next falling edge
  always @(posedge clk) rdIssued <= rstN && rdEn && !emptyFlag;
  always @(negedge clk) begin
    if (rdIssued) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL R2 actual=%h expected=none", rdData);
      end else begin
        lastWord = expQ.pop_front();
        checkEq("R2 read order", rdData, lastWord);
      end
    end
  end

  task automatic cycle(input bit w, input logic [DW-1:0] d, input bit r);
    @(negedge clk);
    wrEn = w; wrData = d; rdEn = r;
    if (r && mdl.size() > 0) expQ.push_back(mdl.pop_front());
    if (w && mdl.size() < 16) mdl.push_back(d);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic doReset(input bit hold);
    @(negedge clk);
    rstN = 1'b0; holdEn = hold; mdl.delete(); expQ.delete();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset(1'b0);
    // R10 / R11 reset state
    checkEq("R10 empty", emptyFlag, 1);
    checkEq("R10 full", fullFlag, 0);
    checkEq("R10 almostFull", almostFull, 0);
    checkEq("R10 errs", {wrErr, rdErr}, 0);
    checkEq("R11 zero at reset", rdData, 0);
    for (int i = 0; i < 3; i++) cycle(1'b1, DW'(16'h1100 + i), 1'b0);
    checkEq("R11 zero before read", rdData, 0);
    for (int i = 0; i < 3; i++) cycle(1'b0, '0, 1'b1);
    checkEq("R10 empty after drain", emptyFlag, 1);
    repeat (3) @(negedge clk);
    checkEq("R3 word held while idle", rdData, 16'h1102);
    // R7 read while empty
    cycle(1'b0, '0, 1'b1);
    checkEq("R7 rdErr pulse", rdErr, 1);
    checkEq("R7 output unchanged", rdData, 16'h1102);
    @(negedge clk);
    checkEq("R7 rdErr one cycle", rdErr, 0);
    // R4 / R8 / R1: sixteen writes after empty, last-read slot is reused by the 16th
    for (int i = 0; i < 15; i++) cycle(1'b1, DW'(16'h2200 + i), 1'b0);
    checkEq("R8 almostFull at 15", almostFull, 1);
    checkEq("R3 word held across writes", rdData, 16'h1102);
    checkEq("R1 not full at 15", fullFlag, 0);
    cycle(1'b1, 16'h22FF, 1'b0);
    checkEq("R4 output shows overwrite", rdData, 16'h22FF);
    checkEq("R1 full at 16", fullFlag, 1);
    checkEq("R8 almostFull off when full", almostFull, 0);
    // R6 write while full
    cycle(1'b1, 16'hDEAD, 1'b0);
    checkEq("R6 wrErr pulse", wrErr, 1);
    @(negedge clk);
    checkEq("R6 wrErr one cycle", wrErr, 0);
    for (int i = 0; i < 16; i++) cycle(1'b0, '0, 1'b1);
    checkEq("R6 refused word not stored", emptyFlag, 1);
    // R9 joint read and write
    cycle(1'b1, 16'h3300, 1'b0);
    cycle(1'b1, 16'h3301, 1'b0);
    for (int i = 0; i < 4; i++) cycle(1'b1, DW'(16'h3310 + i), 1'b1);
    checkEq("R9 not empty after joint", emptyFlag, 0);
    cycle(1'b0, '0, 1'b1);
    checkEq("R9 one left", emptyFlag, 0);
    cycle(1'b0, '0, 1'b1);
    checkEq("R9 occupancy kept", emptyFlag, 1);
    // R5 hold latch mode
    doReset(1'b1);
    checkEq("R11 zero in hold mode", rdData, 0);
    cycle(1'b1, 16'h4444, 1'b0);
    cycle(1'b0, '0, 1'b1);
    for (int i = 0; i < 16; i++) cycle(1'b1, DW'(16'h5500 + i), 1'b0);
    checkEq("R1 full in hold mode", fullFlag, 1);
    checkEq("R5 hold keeps last word", rdData, 16'h4444);
    for (int i = 0; i < 16; i++) cycle(1'b0, '0, 1'b1);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule